// File: doc/BRIEF.md
# Register-Mapped Waveform Capture Engine

This block is an embedded logic-analyzer core. A debug bus `probe` is written into on-chip sample memory once a capture has been armed and the `trig` input is seen high. From that point the core stores one sample per clock until the memory is full. A host drives the block through a simple address/command port. The host uses that port to learn the probe width, the memory depth and a version number. It also uses it to arm or cancel a capture, to poll progress, and to read the stored samples back.

The core claims a reserved window of sixteen addresses at the top of the 32-bit space, 0xFFFFFFF0 to 0xFFFFFFFF. Commands that fall in the window are consumed by the core and are not forwarded on `user_cmd_valid`. All other commands pass through to the user register path unchanged. Trigger-condition evaluation is done outside the block and reaches it as the single `trig` input. A host that wants an immediate capture simply holds `trig` high.

Top module: `wave_capture_core`

## Requirements
- R1: After a synchronous active-low reset, the armed, capturing and done flags, the sample write pointer and the readout address are all zero, and `rsp_valid` is low.
- R2: A read of window offset 0x2 returns the probe width. A read of offset 0x3 returns the capture depth. A read of offset 0x4 returns the version parameter. All are zero-extended to 32 bits.
- R3: A command is decoded only when `cmd_addr[31:4]` is all ones. `user_cmd_valid` equals `cmd_valid` for addresses outside that window and is low for addresses inside it.
- R4: Each read inside the window produces `rsp_valid` high for exactly the one cycle after the request. Writes and commands outside the window never raise it.
- R5: A write to offset 0x0 with bit 0 set arms the core: the status register at offset 0x1 reads 1 (bit 0 armed, bit 1 capturing, bit 2 done), and done and the write pointer are cleared. This happens from any state.
- R6: While armed, the `probe` value present in the first cycle with `trig` high is stored as sample 0, and the core moves to capturing. If `trig` is held high, this is the cycle right after the arming write.
- R7: While capturing, the core stores one sample per cycle at consecutive addresses. After DEPTH samples it sets done, and it stores nothing more until it is re-armed.
- R8: A write to offset 0x0 with bit 0 clear returns the core to idle (status 0) from any state. Once idle, `trig` has no effect.
- R9: Offset 0x5 is the readout address: a write loads its low log2(DEPTH) bits, and a read returns it. A read of offset 0x6 returns the sample at the readout address and then advances the address by one, wrapping from DEPTH-1 to 0.
- R10: Reads of offsets 0x0 and 0x7 to 0xF return zero. Writes to offsets other than 0x0 and 0x5 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 32 | Command address |
| cmd_wdata | input | 32 | Write data |
| trig | input | 1 | Trigger condition met this cycle |
| probe | input | DATA_W | Debug bus to be sampled |
| user_cmd_valid | output | 1 | `cmd_valid` with window commands removed |
| rsp_valid | output | 1 | One-cycle read data-ready flag |
| rsp_data | output | 32 | Read response data |

## Verification
The assertions watch the control sequencing on every cycle. Arming always lands in the armed state with done clear, cancelling always reaches idle, a trigger while armed always starts a capture, the last write always ends in done, and done holds until the next control write. They also check that every window read is answered on the next cycle and that a sample read advances the readout address by exactly one. Only the bench's scenarios show the data content. That content covers which probe value becomes sample 0, the order of the stored samples, the readout wrap, the discovery values, the hiding of window commands from the user path, and the read-only offsets ignoring writes.

// File: rtl/wcap_pkg.sv
// Package: shared state type and register-window constants for the
// waveform capture engine. Assumes a 32-bit address with a 16-entry window.
package wcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DONE    = 2'd3
    } cap_state_t;

    localparam int          ADDR_W   = 32;
    localparam int          OFS_W    = 4;
    localparam logic [27:0] WIN_TAG  = 28'hFFF_FFFF;

    localparam logic [3:0]  OFS_CTRL   = 4'h0;
    localparam logic [3:0]  OFS_STATUS = 4'h1;
    localparam logic [3:0]  OFS_WIDTH  = 4'h2;
    localparam logic [3:0]  OFS_DEPTH  = 4'h3;
    localparam logic [3:0]  OFS_VER    = 4'h4;
    localparam logic [3:0]  OFS_RDADDR = 4'h5;
    localparam logic [3:0]  OFS_SAMPLE = 4'h6;

endpackage

// File: rtl/wcap_ctrl.sv
// Module: capture sequencer. Walks idle -> armed -> capturing -> done and
// produces the sample-memory write strobe and address.
// Assumes: DEPTH is a power of two and at least 2; an arm request takes
// priority over a cancel, and both take priority over the trigger.
module wcap_ctrl
    import wcap_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_req,
    input  logic          cancel_req,
    input  logic          trig,
    output logic          armed,
    output logic          capturing,
    output logic          done,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    cap_state_t    state;
    logic [AW-1:0] wptr;

    // Decode the state into the status flags.
    always_comb begin
        armed     = (state == ST_ARMED);
        capturing = (state == ST_CAPTURE);
        done      = (state == ST_DONE);
    end

    // Generate the sample write strobe; a control write this cycle suppresses it.
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = wptr;
        if (!arm_req && !cancel_req) begin
            if (state == ST_ARMED && trig) begin
                wr_en   = 1'b1;
                wr_addr = '0;
            end else if (state == ST_CAPTURE) begin
                wr_en = 1'b1;
            end
        end
    end

    // Advance the capture state and the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wptr  <= '0;
        end else if (arm_req) begin
            state <= ST_ARMED;
            wptr  <= '0;
        end else if (cancel_req) begin
            state <= ST_IDLE;
            wptr  <= '0;
        end else begin
            case (state)
                ST_ARMED: if (trig) begin
                    state <= ST_CAPTURE;
                    wptr  <= AW'(1);
                end
                ST_CAPTURE: if (wptr == LAST) begin
                    state <= ST_DONE;
                end else begin
                    wptr <= wptr + AW'(1);
                end
                default: ;
            endcase
        end
    end

    // R5: arming always lands in armed with done cleared.
    p_arm_sets_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arm_req |=> (armed && !done));

    // R6: a trigger seen while armed starts the capture.
    p_trig_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && trig && !arm_req && !cancel_req) |=> capturing);

    // R7: the final write ends the capture.
    p_fill_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (capturing && wr_en && wr_addr == LAST) |=> done);

    // R7: done holds until a control write.
    p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm_req && !cancel_req) |=> (done && !wr_en));

    // R8: a cancel reaches idle.
    p_cancel_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_req && !arm_req) |=> (!armed && !capturing && !done));

endmodule

// File: rtl/wcap_mem.sv
// Module: sample memory, DEPTH words of DATA_W bits, one write port and one
// asynchronous read port. Assumes contents are undefined until written, so
// it carries no reset.
module wcap_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] store [DEPTH];

    // Write one sample per strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Present the sample selected by the readout address.
    always_comb begin
        rd_data = store[rd_addr];
    end

endmodule

// File: rtl/wcap_regs.sv
// Module: register window decode. Filters window commands from the user
// path, turns control writes into arm/cancel requests, keeps the readout
// address and registers one-cycle read responses.
// Assumes: DEPTH is a power of two and at least 2; DATA_W is 1 to 32.
module wcap_regs
    import wcap_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 256,
    parameter int VERSION = 1,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [AW-1:0]     wdata_low,
    input  logic              armed,
    input  logic              capturing,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_sample,
    output logic              arm_req,
    output logic              cancel_req,
    output logic [AW-1:0]     rd_addr,
    output logic              user_cmd_valid,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data
);

    logic             in_win;
    logic             rd_hit;
    logic             wr_hit;
    logic [OFS_W-1:0] ofs;
    logic [31:0]      rd_mux;

    // Classify the incoming command against the reserved window.
    always_comb begin
        in_win         = (cmd_addr[ADDR_W-1:OFS_W] == WIN_TAG);
        ofs            = cmd_addr[OFS_W-1:0];
        rd_hit         = cmd_valid && in_win && !cmd_write;
        wr_hit         = cmd_valid && in_win && cmd_write;
        user_cmd_valid = cmd_valid && !in_win;
        arm_req        = wr_hit && (ofs == OFS_CTRL) && wdata_low[0];
        cancel_req     = wr_hit && (ofs == OFS_CTRL) && !wdata_low[0];
    end

    // Select the read data for the addressed offset.
    always_comb begin
        case (ofs)
            OFS_STATUS: rd_mux = {29'd0, done, capturing, armed};
            OFS_WIDTH:  rd_mux = 32'(DATA_W);
            OFS_DEPTH:  rd_mux = 32'(DEPTH);
            OFS_VER:    rd_mux = 32'(VERSION);
            OFS_RDADDR: rd_mux = 32'(rd_addr);
            OFS_SAMPLE: rd_mux = 32'(rd_sample);
            default:    rd_mux = 32'd0;
        endcase
    end

    // Load or post-increment the readout address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr <= '0;
        end else if (wr_hit && ofs == OFS_RDADDR) begin
            rd_addr <= wdata_low;
        end else if (rd_hit && ofs == OFS_SAMPLE) begin
            rd_addr <= rd_addr + AW'(1);
        end
    end

    // Register the read response and its one-cycle data-ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_hit;
            if (rd_hit) begin
                rsp_data <= rd_mux;
            end
        end
    end

    // R4: every window read is answered on the next cycle.
    p_read_answered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> rsp_valid);

    // R4: a response only follows a window read.
    p_rsp_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rd_hit));

    // R9: a sample read advances the readout address by one.
    p_rdaddr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && ofs == OFS_SAMPLE) |=> (rd_addr == $past(rd_addr) + AW'(1)));

endmodule

// File: rtl/wave_capture_core.sv
// Module: top of the waveform capture engine. Joins the register window,
// the capture sequencer and the sample memory.
// Assumes: DATA_W in 1..32, DEPTH a power of two >= 2, synchronous active-low reset.
module wave_capture_core
    import wcap_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 256,
    parameter int VERSION = 1,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [31:0]       cmd_addr,
    input  logic [31:0]       cmd_wdata,
    input  logic              trig,
    input  logic [DATA_W-1:0] probe,
    output logic              user_cmd_valid,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data
);

    logic              arm_req;
    logic              cancel_req;
    logic              armed;
    logic              capturing;
    logic              done;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] rd_sample;

    wcap_regs #(
        .DATA_W  (DATA_W),
        .DEPTH   (DEPTH),
        .VERSION (VERSION)
    ) i_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_write      (cmd_write),
        .cmd_addr       (cmd_addr),
        .wdata_low      (cmd_wdata[AW-1:0]),
        .armed          (armed),
        .capturing      (capturing),
        .done           (done),
        .rd_sample      (rd_sample),
        .arm_req        (arm_req),
        .cancel_req     (cancel_req),
        .rd_addr        (rd_addr),
        .user_cmd_valid (user_cmd_valid),
        .rsp_valid      (rsp_valid),
        .rsp_data       (rsp_data)
    );

    wcap_ctrl #(
        .DEPTH (DEPTH)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_req    (arm_req),
        .cancel_req (cancel_req),
        .trig       (trig),
        .armed      (armed),
        .capturing  (capturing),
        .done       (done),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr)
    );

    wcap_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) i_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (probe),
        .rd_addr (rd_addr),
        .rd_data (rd_sample)
    );

endmodule

// File: tb/test_wave_capture_core.sv
// Bench: behavioural reference model of the capture engine, compared with the
// design at every falling edge, plus named scenario checks per requirement.
module test_wave_capture_core;

    localparam int          CLK_PERIOD = 10;
    localparam int          DW   = 8;
    localparam int          DP   = 16;
    localparam int          VER  = 3;
    localparam logic [31:0] BASE = 32'hFFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic        trig = 1'b0;
    logic [DW-1:0] probe = 8'h11;
    logic        user_cmd_valid;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;
    string tag = "R1";

    // reference model state: 0 idle, 1 armed, 2 capturing, 3 done
    int        m_state = 0;
    int        m_wptr = 0;
    int        m_rptr = 0;
    logic [7:0] m_mem [DP];
    bit        m_rv = 0;
    logic [31:0] m_rd = '0;

    wave_capture_core #(.DATA_W(DW), .DEPTH(DP), .VERSION(VER)) i_wave_capture_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_write      (cmd_write),
        .cmd_addr       (cmd_addr),
        .cmd_wdata      (cmd_wdata),
        .trig           (trig),
        .probe          (probe),
        .user_cmd_valid (user_cmd_valid),
        .rsp_valid      (rsp_valid),
        .rsp_data       (rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // probe changes every cycle, after the design has sampled it
    always @(posedge clk) probe <= probe + 8'h3B;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model update at each rising edge
    always @(posedge clk) begin
        bit hit;
        int ofs;
        if (!rst_n) begin
            m_state = 0; m_wptr = 0; m_rptr = 0; m_rv = 0; m_rd = '0;
        end else begin
            hit  = cmd_valid && (cmd_addr[31:4] == 28'hFFF_FFFF);
            ofs  = int'(cmd_addr[3:0]);
            m_rv = hit && !cmd_write;
            if (m_rv) begin
                case (ofs)
                    1: m_rd = {29'd0, m_state == 3, m_state == 2, m_state == 1};
                    2: m_rd = DW;
                    3: m_rd = DP;
                    4: m_rd = VER;
                    5: m_rd = m_rptr;
                    6: begin
                        m_rd   = {24'd0, m_mem[m_rptr]};
                        m_rptr = (m_rptr + 1) % DP;
                    end
                    default: m_rd = '0;
                endcase
            end
            if (hit && cmd_write && ofs == 5) m_rptr = int'(cmd_wdata[3:0]);
            if (hit && cmd_write && ofs == 0) begin
                m_state = cmd_wdata[0] ? 1 : 0;
                m_wptr  = 0;
            end else if (m_state == 1 && trig) begin
                m_mem[0] = probe;
                m_wptr   = 1;
                m_state  = 2;
            end else if (m_state == 2) begin
                m_mem[m_wptr] = probe;
                if (m_wptr == DP - 1) m_state = 3;
                else m_wptr++;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && started) begin
            check(rsp_valid === m_rv, tag, "rsp_valid vs model", 32'(rsp_valid), 32'(m_rv));
            if (m_rv) check(rsp_data === m_rd, tag, "rsp_data vs model", rsp_data, m_rd);
            check(user_cmd_valid === (cmd_valid && cmd_addr[31:4] != 28'hFFF_FFFF), "R3",
                  "user_cmd_valid vs model", 32'(user_cmd_valid),
                  32'(cmd_valid && cmd_addr[31:4] != 28'hFFF_FFFF));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=%0d expected<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic op(input bit wr, input logic [31:0] addr, input logic [31:0] d);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = addr; cmd_wdata = d;
        @(negedge clk); #1;
        cmd_valid = 1'b0; cmd_write = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] ofs, input logic [31:0] exp, input string req);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = BASE | 32'(ofs);
        @(negedge clk);
        check(rsp_valid === 1'b1 && rsp_data === exp, req, "window read",
              rsp_data, exp);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    initial begin
        logic [7:0] s0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        started = 1;
        // R1: reset state
        tag = "R1";
        check(rsp_valid === 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
        rd_chk(4'h1, 0, "R1");
        rd_chk(4'h5, 0, "R1");

        // R2: discovery registers
        tag = "R2";
        rd_chk(4'h2, DW, "R2");
        rd_chk(4'h3, DP, "R2");
        rd_chk(4'h4, VER, "R2");

        // R3/R4: outside-window commands pass through, no response
        tag = "R3";
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 32'hFFFF_FFEF;
        @(negedge clk);
        check(user_cmd_valid === 1'b1, "R3", "outside read forwarded", 32'(user_cmd_valid), 1);
        check(rsp_valid === 1'b0, "R4", "no response outside window", 32'(rsp_valid), 0);
        #1 cmd_write = 1'b1; cmd_addr = 32'h0000_0010;
        @(negedge clk);
        check(user_cmd_valid === 1'b1, "R3", "outside write forwarded", 32'(user_cmd_valid), 1);
        #1 cmd_addr = BASE | 32'h8;
        @(negedge clk);
        check(user_cmd_valid === 1'b0, "R3", "window write hidden", 32'(user_cmd_valid), 0);
        check(rsp_valid === 1'b0, "R4", "no response to write", 32'(rsp_valid), 0);
        #1 cmd_valid = 1'b0; cmd_write = 1'b0;
        idle(1);
        check(rsp_valid === 1'b0, "R4", "flag lasts one cycle", 32'(rsp_valid), 0);

        // R5/R6/R7: arm, wait, trigger, fill
        tag = "R5";
        op(1'b1, BASE, 32'h1);
        idle(3);
        rd_chk(4'h1, 32'h1, "R5");
        tag = "R6";
        trig = 1'b1;
        s0 = probe;
        idle(1);
        trig = 1'b0;
        rd_chk(4'h1, 32'h2, "R6");
        tag = "R7";
        idle(DP);
        rd_chk(4'h1, 32'h4, "R7");
        idle(5);
        rd_chk(4'h1, 32'h4, "R7");

        // R9: readout and wrap
        tag = "R9";
        op(1'b1, BASE | 32'h5, 32'h0);
        rd_chk(4'h6, {24'd0, s0}, "R6");
        for (int i = 1; i < DP; i++) rd_chk(4'h6, {24'd0, m_mem[i]}, "R7");
        rd_chk(4'h5, 32'h0, "R9");
        op(1'b1, BASE | 32'h5, 32'hFFFF_FF2F);
        rd_chk(4'h5, 32'hF, "R9");
        rd_chk(4'h6, {24'd0, m_mem[DP-1]}, "R9");
        rd_chk(4'h6, {24'd0, m_mem[0]}, "R9");
        rd_chk(4'h5, 32'h1, "R9");

        // R10: read-only offsets ignore writes, unmapped reads zero
        tag = "R10";
        op(1'b1, BASE | 32'h2, 32'h99);
        rd_chk(4'h2, DW, "R10");
        op(1'b1, BASE | 32'h6, 32'h55);
        rd_chk(4'h5, 32'h1, "R10");
        rd_chk(4'h7, 0, "R10");
        rd_chk(4'hF, 0, "R10");
        rd_chk(4'h0, 0, "R10");

        // R6: trigger held high, capture starts the cycle after arming
        tag = "R6";
        trig = 1'b1;
        op(1'b1, BASE, 32'h1);
        s0 = probe;
        idle(DP + 2);
        rd_chk(4'h1, 32'h4, "R6");
        op(1'b1, BASE | 32'h5, 32'h0);
        rd_chk(4'h6, {24'd0, s0}, "R6");

        // R8: cancel while armed, during capture, and trigger ignored when idle
        tag = "R8";
        trig = 1'b0;
        op(1'b1, BASE, 32'h1);
        op(1'b1, BASE, 32'h0);
        rd_chk(4'h1, 0, "R8");
        trig = 1'b1;
        op(1'b1, BASE, 32'h1);
        idle(3);
        rd_chk(4'h1, 32'h2, "R8");
        op(1'b1, BASE, 32'h2);
        idle(4);
        rd_chk(4'h1, 0, "R8");
        trig = 1'b0;

        // R5: re-arm from done clears done
        tag = "R5";
        trig = 1'b1;
        op(1'b1, BASE, 32'h1);
        idle(DP + 2);
        trig = 1'b0;
        rd_chk(4'h1, 32'h4, "R7");
        op(1'b1, BASE, 32'h1);
        rd_chk(4'h1, 32'h1, "R5");
        op(1'b1, BASE, 32'h0);
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule